// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It runs in its own receive clock domain. A sampling tick enable, pulsing at sixteen times the bit rate, paces all activity, and the tick is independent of whatever timing the transmitter uses. The line input first passes through a synchronizer. After that the receiver waits for a falling edge and confirms the start bit at the centre of its cell. It then samples every later bit at the centre of its own cell.

While a character is coming in, a shift register assembles it. When the character is complete it moves into a holding register, which presents it to the host together with a data-ready flag. Parity, framing, break and overrun conditions each set a sticky flag. A pulse on the data-read strobe clears data-ready. A pulse on the status-read strobe clears the four error flags. Character length and parity mode come from static configuration inputs.

Top module: `oversample_rx`

## Requirements
- R1: After a synchronous reset, data-ready, all four error flags and the received data output are zero.
- R2: The character length is set by `cfg_len_i`: 00 selects 5 bits, 01 selects 6, 10 selects 7 and 11 selects 8. The first data bit on the line becomes bit 0 of `rx_data_o`. Bits above the character length read as zero. A completed character sets `data_ready_o`.
- R3: A falling edge starts reception only if the line is still low 8 ticks later, at the centre of the start cell. If it is not, the receiver returns to idle: it loads no character and sets no flag.
- R4: When `cfg_par_en_i` is 1, one parity bit follows the data bits. With `cfg_par_odd_i` = 0 the data bits plus the parity bit must hold an even number of ones; with 1 they must hold an odd number. A mismatch sets `parity_err_o`, and the character is still delivered.
- R5: A first stop bit sampled low sets `framing_err_o` and still delivers the character, unless R6 applies.
- R6: When the start bit, all data bits, the parity bit (if enabled) and the stop bit are all sampled low, the receiver sets `break_o` and loads no character. It then starts no new reception until the line has returned high.
- R7: If a character completes while `data_ready_o` is still set, `overrun_o` is set and the new character replaces the one held.
- R8: A one-cycle pulse on `rd_data_i` clears `data_ready_o` on the next clock edge. The data register keeps its value.
- R9: The error flags are sticky. A pulse on `rd_status_i` clears all four. A flag set in the same cycle as the clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick_i | input | 1 | Sampling tick enable, OSR ticks per bit |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| cfg_len_i | input | 2 | Character length select (R2) |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rd_data_i | input | 1 | Host read strobe for the data register |
| rd_status_i | input | 1 | Host read strobe for the error flags |
| rx_data_o | output | DATA_W | Held received character |
| data_ready_o | output | 1 | Unread character is held |
| overrun_o | output | 1 | Sticky overrun flag |
| parity_err_o | output | 1 | Sticky parity error flag |
| framing_err_o | output | 1 | Sticky framing error flag |
| break_o | output | 1 | Sticky line break flag |

## Verification
The bench builds the receiver with its defaults: an 8-bit maximum character, sixteen ticks per bit and a two-stage synchronizer. It pulses the tick once every four clocks, so each bit cell lasts 64 cycles. That long cell lets the bench drive a start pulse shorter than half a cell to exercise false-start rejection. It also leaves room to hold a bad stop bit low for most of its cell without the tail being taken as a new start. Because every length code is reachable with this setup, the right alignment and zeroed upper bits of 5-, 6- and 7-bit characters can be checked alongside 8-bit ones.

// File: rtl/rx_pkg.sv
package rx_pkg;

  localparam int unsigned CHAR_W_DEF = 8;
  localparam int unsigned OSR_DEF    = 16;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRK
  } rx_state_e;

  typedef struct packed {
    logic perr;
    logic ferr;
  } rx_err_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16,
  localparam int unsigned IDX_W = $clog2(DATA_W),
  localparam int unsigned CNT_W = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [IDX_W:0]    char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic              brk_o,
  output logic [DATA_W-1:0] data_o,
  output rx_err_t           err_o
);

  localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] CELL_LAST = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W:0]    bit_idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_acc_q;
  logic              all_zero_q;
  logic              perr_q;
  logic [IDX_W:0]    shamt;
  logic              cell_end;

  assign shamt    = (IDX_W + 1)'(DATA_W) - char_len_i;
  assign cell_end = (cnt_q == CELL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      bit_idx_q  <= '0;
      shreg_q    <= '0;
      par_acc_q  <= 1'b0;
      all_zero_q <= 1'b1;
      perr_q     <= 1'b0;
      done_o     <= 1'b0;
      brk_o      <= 1'b0;
      data_o     <= '0;
      err_o      <= '0;
    end else begin
      done_o <= 1'b0;
      brk_o  <= 1'b0;
      if (tick_i) begin
        case (state_q)
          RX_IDLE: begin
            if (!rxd_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == MID_LAST) begin
              cnt_q <= '0;
              if (rxd_i) begin
                state_q <= RX_IDLE;
              end else begin
                state_q    <= RX_DATA;
                bit_idx_q  <= '0;
                par_acc_q  <= 1'b0;
                all_zero_q <= 1'b1;
                perr_q     <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cell_end) begin
              cnt_q     <= '0;
              shreg_q   <= {rxd_i, shreg_q[DATA_W-1:1]};
              par_acc_q <= par_acc_q ^ rxd_i;
              if (rxd_i) all_zero_q <= 1'b0;
              if (bit_idx_q == char_len_i - 1'b1) begin
                state_q <= par_en_i ? RX_PAR : RX_STOP;
              end else begin
                bit_idx_q <= bit_idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (cell_end) begin
              cnt_q   <= '0;
              perr_q  <= ((par_acc_q ^ rxd_i) != par_odd_i);
              if (rxd_i) all_zero_q <= 1'b0;
              state_q <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cell_end) begin
              cnt_q <= '0;
              if (!rxd_i && all_zero_q) begin
                brk_o   <= 1'b1;
                state_q <= RX_BRK;
              end else begin
                done_o     <= 1'b1;
                data_o     <= shreg_q >> shamt;
                err_o.perr <= perr_q;
                err_o.ferr <= !rxd_i;
                state_q    <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_BRK: begin
            if (rxd_i) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_hold_status.sv
module rx_hold_status
  import rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic              brk_i,
  input  logic [DATA_W-1:0] data_i,
  input  rx_err_t           err_i,
  input  logic              rd_data_i,
  input  logic              rd_status_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);

  logic ovr_evt;

  assign ovr_evt = done_i && ready_o && !rd_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
      brk_o     <= 1'b0;
    end else begin
      if (done_i) begin
        data_o  <= data_i;
        ready_o <= 1'b1;
      end else if (rd_data_i) begin
        ready_o <= 1'b0;
      end

      if (ovr_evt)                  overrun_o <= 1'b1;
      else if (rd_status_i)         overrun_o <= 1'b0;

      if (done_i && err_i.perr)     perr_o <= 1'b1;
      else if (rd_status_i)         perr_o <= 1'b0;

      if (done_i && err_i.ferr)     ferr_o <= 1'b1;
      else if (rd_status_i)         ferr_o <= 1'b0;

      if (brk_i)                    brk_o <= 1'b1;
      else if (rd_status_i)         brk_o <= 1'b0;
    end
  end

endmodule

// File: rtl/oversample_rx.sv
module oversample_rx
  import rx_pkg::*;
#(
  parameter int unsigned DATA_W      = rx_pkg::CHAR_W_DEF,
  parameter int unsigned OSR         = rx_pkg::OSR_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        cfg_len_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              rd_data_i,
  input  logic              rd_status_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              data_ready_o,
  output logic              overrun_o,
  output logic              parity_err_o,
  output logic              framing_err_o,
  output logic              break_o
);

  logic              rxd_s;
  logic [IDX_W:0]    char_len;
  logic              frame_done;
  logic              frame_brk;
  logic [DATA_W-1:0] frame_data;
  rx_err_t           frame_err;

  assign char_len = (IDX_W + 1)'(DATA_W - 3) + (IDX_W + 1)'(cfg_len_i);

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd_i),
    .dout (rxd_s)
  );

  rx_frame_engine #(.DATA_W(DATA_W), .OSR(OSR)) eng_i (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (rx_tick_i),
    .rxd_i      (rxd_s),
    .char_len_i (char_len),
    .par_en_i   (cfg_par_en_i),
    .par_odd_i  (cfg_par_odd_i),
    .done_o     (frame_done),
    .brk_o      (frame_brk),
    .data_o     (frame_data),
    .err_o      (frame_err)
  );

  rx_hold_status #(.DATA_W(DATA_W)) hold_i (
    .clk         (clk),
    .rst         (rst),
    .done_i      (frame_done),
    .brk_i       (frame_brk),
    .data_i      (frame_data),
    .err_i       (frame_err),
    .rd_data_i   (rd_data_i),
    .rd_status_i (rd_status_i),
    .data_o      (rx_data_o),
    .ready_o     (data_ready_o),
    .overrun_o   (overrun_o),
    .perr_o      (parity_err_o),
    .ferr_o      (framing_err_o),
    .brk_o       (break_o)
  );

endmodule

// File: rtl/oversample_rx_checker.sv
module oversample_rx_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_data_i,
  input logic              rd_status_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              data_ready_o,
  input logic              overrun_o,
  input logic              parity_err_o,
  input logic              framing_err_o,
  input logic              break_o,
  input logic              frame_done,
  input logic              frame_brk,
  input logic              frame_perr,
  input logic              frame_ferr
);

  logic rst_seen_q;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst_seen_q && !rst) begin
      assert_reset_clear_R1: assert (!data_ready_o && !overrun_o && !parity_err_o &&
                                     !framing_err_o && !break_o && rx_data_o == '0)
        else $error("R1 outputs not cleared by reset");
    end
  end

  assert_ready_set_R2: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> data_ready_o);

  assert_perr_set_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_perr) |=> parity_err_o);

  assert_ferr_set_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_ferr) |=> framing_err_o);

  assert_break_set_R6: assert property (@(posedge clk) disable iff (rst)
    frame_brk |=> break_o);

  assert_break_noload_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_brk && !data_ready_o) |=> !data_ready_o);

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && data_ready_o && !rd_data_i) |=> overrun_o);

  assert_ready_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_data_i && !frame_done) |=> !data_ready_o);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(rx_data_o));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !rd_status_i) |=> overrun_o);

endmodule

bind oversample_rx oversample_rx_checker #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .rd_data_i     (rd_data_i),
  .rd_status_i   (rd_status_i),
  .rx_data_o     (rx_data_o),
  .data_ready_o  (data_ready_o),
  .overrun_o     (overrun_o),
  .parity_err_o  (parity_err_o),
  .framing_err_o (framing_err_o),
  .break_o       (break_o),
  .frame_done    (frame_done),
  .frame_brk     (frame_brk),
  .frame_perr    (frame_err.perr),
  .frame_ferr    (frame_err.ferr)
);

// File: tb/oversample_rx_tb.sv
`timescale 1ns/1ps
module oversample_rx_tb_top;

  localparam int TDIV = 4;
  localparam int BIT  = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] tdiv_q = '0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_data;
  logic       ready, ovr, perr, ferr, brk;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      tdiv_q <= '0;
      tick   <= 1'b0;
    end else begin
      tdiv_q <= tdiv_q + 1'b1;
      tick   <= (tdiv_q == 2'(TDIV - 2));
    end
  end

  oversample_rx dut_i (
    .clk           (clk),
    .rst           (rst),
    .rx_tick_i     (tick),
    .rxd_i         (rxd),
    .cfg_len_i     (cfg_len),
    .cfg_par_en_i  (par_en),
    .cfg_par_odd_i (par_odd),
    .rd_data_i     (rd_data),
    .rd_status_i   (rd_status),
    .rx_data_o     (rx_data),
    .data_ready_o  (ready),
    .overrun_o     (ovr),
    .parity_err_o  (perr),
    .framing_err_o (ferr),
    .break_o       (brk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int cycles);
    rxd = b;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic pulse_rd_data();
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_rd_status();
    rd_status = 1'b1;
    @(negedge clk);
    rd_status = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    pulse_rd_data();
    pulse_rd_status();
  endtask

  // Sends one character; good_stop = 0 holds the stop bit low for three quarters of a cell.
  task automatic send_char(input logic [7:0] d, input int len, input logic flip_par,
                           input logic good_stop);
    logic p;
    p = par_odd ^ flip_par;
    hold(1'b0, BIT);
    for (int i = 0; i < len; i++) begin
      hold(d[i], BIT);
      p = p ^ d[i];
    end
    if (par_en) hold(p, BIT);
    if (good_stop) begin
      hold(1'b1, BIT);
    end else begin
      hold(1'b0, 3 * BIT / 4);
      hold(1'b1, BIT / 4);
    end
    hold(1'b1, 2 * BIT);
  endtask

  task automatic t_reset();
    chk("R1 ready", {31'b0, ready}, 0);
    chk("R1 flags", {28'b0, ovr, perr, ferr, brk}, 0);
    chk("R1 data", {24'b0, rx_data}, 0);
  endtask

  task automatic t_lengths();
    cfg_len = 2'b11; par_en = 1'b0;
    send_char(8'hA5, 8, 1'b0, 1'b1);
    chk("R2 len8 ready", {31'b0, ready}, 1);
    chk("R2 len8 data", {24'b0, rx_data}, 32'hA5);
    chk("R2 len8 no errors", {28'b0, ovr, perr, ferr, brk}, 0);
    pulse_rd_data();
    chk("R8 ready cleared", {31'b0, ready}, 0);
    chk("R8 data kept", {24'b0, rx_data}, 32'hA5);
    cfg_len = 2'b00;
    send_char(8'hFF, 5, 1'b0, 1'b1);
    chk("R2 len5 data", {24'b0, rx_data}, 32'h1F);
    pulse_rd_data();
    cfg_len = 2'b01;
    send_char(8'h2D, 6, 1'b0, 1'b1);
    chk("R2 len6 data", {24'b0, rx_data}, 32'h2D);
    pulse_rd_data();
    cfg_len = 2'b10;
    send_char(8'h55, 7, 1'b0, 1'b1);
    chk("R2 len7 data", {24'b0, rx_data}, 32'h55);
    chk("R2 len7 no errors", {28'b0, ovr, perr, ferr, brk}, 0);
    clear_all();
    cfg_len = 2'b11;
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send_char(8'h37, 8, 1'b0, 1'b1);
    chk("R4 even ok", {31'b0, perr}, 0);
    chk("R4 even data", {24'b0, rx_data}, 32'h37);
    pulse_rd_data();
    send_char(8'h37, 8, 1'b1, 1'b1);
    chk("R4 even bad", {31'b0, perr}, 1);
    chk("R4 delivered", {31'b0, ready}, 1);
    pulse_rd_status();
    chk("R9 perr cleared", {31'b0, perr}, 0);
    pulse_rd_data();
    par_odd = 1'b1;
    send_char(8'h80, 8, 1'b0, 1'b1);
    chk("R4 odd ok", {31'b0, perr}, 0);
    pulse_rd_data();
    send_char(8'h80, 8, 1'b1, 1'b1);
    chk("R4 odd bad", {31'b0, perr}, 1);
    clear_all();
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_false_start();
    hold(1'b0, 4 * TDIV);
    hold(1'b1, 3 * BIT);
    chk("R3 no char", {31'b0, ready}, 0);
    chk("R3 no flags", {28'b0, ovr, perr, ferr, brk}, 0);
    send_char(8'h3C, 8, 1'b0, 1'b1);
    chk("R3 rearmed data", {24'b0, rx_data}, 32'h3C);
    clear_all();
  endtask

  task automatic t_framing();
    send_char(8'h6E, 8, 1'b0, 1'b0);
    chk("R5 framing set", {31'b0, ferr}, 1);
    chk("R5 data", {24'b0, rx_data}, 32'h6E);
    chk("R5 not break", {31'b0, brk}, 0);
    clear_all();
  endtask

  task automatic t_break();
    hold(1'b0, 12 * BIT);
    chk("R6 break set", {31'b0, brk}, 1);
    chk("R6 no char", {31'b0, ready}, 0);
    chk("R6 no framing", {31'b0, ferr}, 0);
    hold(1'b0, 12 * BIT);
    chk("R6 no rearm while low", {31'b0, ready}, 0);
    hold(1'b1, 2 * BIT);
    pulse_rd_status();
    chk("R9 break cleared", {31'b0, brk}, 0);
    send_char(8'h81, 8, 1'b0, 1'b1);
    chk("R6 rearm data", {24'b0, rx_data}, 32'h81);
    chk("R6 rearm ready", {31'b0, ready}, 1);
    clear_all();
  endtask

  task automatic t_overrun();
    send_char(8'h11, 8, 1'b0, 1'b1);
    chk("R7 no overrun yet", {31'b0, ovr}, 0);
    send_char(8'hE2, 8, 1'b0, 1'b1);
    chk("R7 overrun set", {31'b0, ovr}, 1);
    chk("R7 overwritten", {24'b0, rx_data}, 32'hE2);
    pulse_rd_data();
    chk("R9 overrun sticky", {31'b0, ovr}, 1);
    pulse_rd_status();
    chk("R9 overrun cleared", {31'b0, ovr}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_parity();
    t_false_start();
    t_framing();
    t_break();
    t_overrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule